// File: doc/BRIEF.md
# Multi-format audio serial receiver

This block is the input side of a slave serial audio port. An external master supplies a bit clock, a frame clock and one serial data line. The block turns that stream into parallel PCM words. It oversamples all three pins with the system clock, brings them into the system domain and finds the active bit clock edge. A position counter then locates each bit inside the frame. The same shift path serves three stereo justifications and an eight-slot time-multiplexed frame.

Configuration inputs choose the format, the word length and the polarity of each clock. All four are held steady while the block runs. Each completed word leaves on a single-cycle strobe. It carries a channel number and a 24-bit left-aligned value. A frame clock edge that arrives before the counter expects it is reported, and the count restarts at that edge.

Top module: `audio_serial_rx`

## Requirements
- R1: With `fmt_sel`=0 (I2S), the left word belongs to the half-frame in which the frame clock is low, and the right word to the half in which it is high. Each word's MSB is on the second bit clock of its half. Left goes out as channel 0 and right as channel 1.
- R2: With `fmt_sel`=1 (left-justified), the left half is the one with the frame clock high. The MSB is on the first bit clock of each half. Left is channel 0 and right is channel 1.
- R3: With `fmt_sel`=2 (right-justified), the left half is the one with the frame clock high. The LSB is on the 32nd bit clock of each half, so the MSB sits word-length bits before the end of the half.
- R4: With `fmt_sel`=3 (TDM), a rising frame clock starts a frame of 8 slots of 32 bit clocks. Slot n's MSB is on bit clock 32n+1, counted from 0 at the rising edge, and the word goes out as channel n.
- R5: `wlen_sel` 0 selects 24 bits, 1 selects 20 and 2 selects 16 (3 acts as 24). Data arrives MSB first. Slot bits past the word length are ignored. `smp_data` holds the word in its top bits and zero below.
- R6: With `bclk_inv`=0, bits are taken on the rising edge of `ser_bclk`. With `bclk_inv`=1 they are taken on its falling edge.
- R7: With `fclk_inv`=1, the frame clock pin is inverted before any of the rules in R1 to R4 are applied.
- R8: `smp_vld` is high for one cycle per completed word. No word is produced after reset until the first frame clock edge has been seen.
- R9: A frame edge that comes before the last bit of the half (stereo) or of the frame (TDM) pulses `frame_err` once. The count restarts at that edge and the interrupted word is dropped. Words after the edge decode correctly.
- R10: In and right after reset, `smp_vld`, `smp_chan`, `smp_data` and `frame_err` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, faster than 4x the bit clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_bclk | input | 1 | Serial bit clock pin |
| ser_fclk | input | 1 | Frame (left/right) clock pin |
| ser_data | input | 1 | Serial data pin |
| fmt_sel | input | 2 | 0 I2S, 1 left-justified, 2 right-justified, 3 TDM |
| wlen_sel | input | 2 | 0 = 24, 1 = 20, 2 = 16 bits |
| bclk_inv | input | 1 | Take bits on the falling bit clock edge |
| fclk_inv | input | 1 | Invert the frame clock |
| smp_vld | output | 1 | One-cycle word strobe |
| smp_chan | output | 3 | Channel of the word |
| smp_data | output | 24 | Left-aligned sample |
| frame_err | output | 1 | Early frame edge pulse |

## Verification
The bench uses the default parameters: 24-bit samples, 32-bit slots, 8 TDM slots and two synchronizer stages. With these, a 256-bit frame runs in about two thousand system cycles, so every combination of format, word length and both clock polarities (48 in all) can be swept, two frames each. Every slot is padded with random bits past the word, so ignoring those bits and zero-filling the low part are checked on every word. A TDM frame cut short at bit 100 exercises the resynchronization, the dropped partial word and the error pulse.

// File: rtl/asrx_pkg.sv
package asrx_pkg;
  typedef enum logic [1:0] {
    FMT_I2S = 2'd0,
    FMT_LJ  = 2'd1,
    FMT_RJ  = 2'd2,
    FMT_TDM = 2'd3
  } fmt_e;

  // word length in bits for a width code
  function automatic int word_len(input logic [1:0] code);
    case (code)
      2'd1:    return 20;
      2'd2:    return 16;
      default: return 24;
    endcase
  endfunction
endpackage

// File: rtl/asrx_edge.sv
module asrx_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic bclk_pin,
  input  logic fclk_pin,
  input  logic data_pin,
  input  logic bclk_inv,
  input  logic fclk_inv,
  output logic tick,
  output logic fclk_lvl,
  output logic data_bit
);
  localparam int TOP = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sb, sf, sd;
  logic b_prev;
  logic b_eff;

  // pin synchronizers: identical depth keeps the three lines aligned
  always_ff @(posedge clk) begin
    sb     <= {sb[SYNC_STAGES-2:0], bclk_pin};
    sf     <= {sf[SYNC_STAGES-2:0], fclk_pin};
    sd     <= {sd[SYNC_STAGES-2:0], data_pin};
    b_prev <= b_eff;
  end

  always_comb begin
    b_eff    = sb[TOP] ^ bclk_inv;
    tick     = !rst && b_eff && !b_prev;
    fclk_lvl = sf[TOP] ^ fclk_inv;
    data_bit = sd[TOP];
  end
endmodule

// File: rtl/asrx_framer.sv
module asrx_framer #(
  parameter int SLOT_W    = 32,
  parameter int TDM_SLOTS = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic tdm,
  input  logic tick,
  input  logic fclk_lvl,
  input  logic data_bit,
  output logic bit_vld,
  output logic [$clog2(SLOT_W*TDM_SLOTS)-1:0] bit_pos,
  output logic bit_d,
  output logic bit_lr,
  output logic ferr
);
  localparam int FRAME_BITS = SLOT_W * TDM_SLOTS;
  localparam int POS_W      = $clog2(FRAME_BITS);
  localparam logic [POS_W-1:0] HALF_LAST  = POS_W'(SLOT_W - 1);
  localparam logic [POS_W-1:0] FRAME_LAST = POS_W'(FRAME_BITS - 1);

  logic primed, locked, lr_prev;
  logic [POS_W-1:0] cnt, cnt_nx;
  logic edge_seen, at_end;

  always_comb begin
    if (tdm) edge_seen = primed && fclk_lvl && !lr_prev;
    else     edge_seen = primed && (fclk_lvl != lr_prev);
    at_end = tdm ? (cnt == FRAME_LAST) : (cnt == HALF_LAST);
    if (edge_seen)                cnt_nx = '0;
    else if (tdm || cnt != '1)    cnt_nx = cnt + 1'b1;
    else                          cnt_nx = cnt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      primed  <= 1'b0;
      locked  <= 1'b0;
      lr_prev <= 1'b0;
      cnt     <= '0;
      bit_vld <= 1'b0;
      bit_pos <= '0;
      bit_d   <= 1'b0;
      bit_lr  <= 1'b0;
      ferr    <= 1'b0;
    end else begin
      bit_vld <= 1'b0;
      ferr    <= 1'b0;
      if (tick) begin
        primed  <= 1'b1;
        lr_prev <= fclk_lvl;
        cnt     <= cnt_nx;
        if (edge_seen) locked <= 1'b1;
        bit_vld <= locked || edge_seen;
        bit_pos <= cnt_nx;
        bit_d   <= data_bit;
        bit_lr  <= fclk_lvl;
        ferr    <= edge_seen && locked && !at_end;
      end
    end
  end

  // an error always coincides with the restarted count
  assert_resync_start_R9: assert property (@(posedge clk) disable iff (rst)
    ferr |-> (bit_vld && bit_pos == '0));
endmodule

// File: rtl/asrx_assemble.sv
module asrx_assemble
  import asrx_pkg::*;
#(
  parameter int SAMPLE_W  = 24,
  parameter int SLOT_W    = 32,
  parameter int TDM_SLOTS = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic [1:0] fmt,
  input  logic [1:0] wcode,
  input  logic bit_vld,
  input  logic [$clog2(SLOT_W*TDM_SLOTS)-1:0] bit_pos,
  input  logic bit_d,
  input  logic bit_lr,
  output logic smp_vld,
  output logic [$clog2(TDM_SLOTS)-1:0] smp_chan,
  output logic [SAMPLE_W-1:0] smp_data
);
  localparam int POS_W = $clog2(SLOT_W * TDM_SLOTS);
  localparam int OFF_W = $clog2(SLOT_W);
  localparam int CH_W  = $clog2(TDM_SLOTS);
  localparam logic [POS_W-1:0] SLOT_P = POS_W'(SLOT_W);

  logic [OFF_W:0]      wlen;
  logic [POS_W-1:0]    pos_m1, rj_start, k_raw;
  logic [OFF_W-1:0]    k;
  logic [CH_W-1:0]     ch;
  logic                in_slot, take_bit, last;
  logic [SAMPLE_W-1:0] acc, acc_nx, low_mask;

  always_comb begin
    wlen     = (OFF_W+1)'(word_len(wcode));
    pos_m1   = bit_pos - 1'b1;
    rj_start = SLOT_P - POS_W'(wlen);
    in_slot  = 1'b0;
    k_raw    = '0;
    ch       = '0;
    case (fmt_e'(fmt))
      FMT_I2S: begin
        in_slot = pos_m1 < SLOT_P;
        k_raw   = pos_m1;
        ch      = CH_W'(bit_lr);
      end
      FMT_LJ: begin
        in_slot = bit_pos < SLOT_P;
        k_raw   = bit_pos;
        ch      = CH_W'(!bit_lr);
      end
      FMT_RJ: begin
        in_slot = (bit_pos >= rj_start) && (bit_pos < SLOT_P);
        k_raw   = bit_pos - rj_start;
        ch      = CH_W'(!bit_lr);
      end
      default: begin
        in_slot = 1'b1;
        k_raw   = pos_m1;
        ch      = pos_m1[POS_W-1:OFF_W];
      end
    endcase
    k        = k_raw[OFF_W-1:0];
    take_bit = bit_vld && in_slot && ({1'b0, k} < wlen);
    last     = take_bit && ({1'b0, k} == wlen - 1'b1);
    acc_nx   = (k == '0) ? '0 : acc;
    if (take_bit) acc_nx[SAMPLE_W-1-int'(k)] = bit_d;
    low_mask = {SAMPLE_W{1'b1}} >> wlen;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc      <= '0;
      smp_vld  <= 1'b0;
      smp_chan <= '0;
      smp_data <= '0;
    end else begin
      smp_vld <= last;
      if (take_bit) acc <= acc_nx;
      if (last) begin
        smp_chan <= ch;
        smp_data <= acc_nx;
      end
    end
  end

  assert_single_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    smp_vld |=> !smp_vld);
  assert_emit_after_bit_R8: assert property (@(posedge clk) disable iff (rst)
    smp_vld |-> $past(bit_vld));
  assert_zero_fill_R5: assert property (@(posedge clk) disable iff (rst)
    smp_vld |-> ((smp_data & low_mask) == '0));
  assert_stereo_chan_R1: assert property (@(posedge clk) disable iff (rst)
    (smp_vld && fmt != FMT_TDM) |-> (smp_chan <= CH_W'(1)));
endmodule

// File: rtl/audio_serial_rx.sv
module audio_serial_rx #(
  parameter int SAMPLE_W    = 24,
  parameter int SLOT_W      = 32,
  parameter int TDM_SLOTS   = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic ser_bclk,
  input  logic ser_fclk,
  input  logic ser_data,
  input  logic [1:0] fmt_sel,
  input  logic [1:0] wlen_sel,
  input  logic bclk_inv,
  input  logic fclk_inv,
  output logic smp_vld,
  output logic [$clog2(TDM_SLOTS)-1:0] smp_chan,
  output logic [SAMPLE_W-1:0] smp_data,
  output logic frame_err
);
  localparam int POS_W = $clog2(SLOT_W * TDM_SLOTS);

  logic tick, fclk_lvl, data_bit;
  logic bit_vld, bit_d, bit_lr;
  logic [POS_W-1:0] bit_pos;

  asrx_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst(rst),
    .bclk_pin(ser_bclk), .fclk_pin(ser_fclk), .data_pin(ser_data),
    .bclk_inv(bclk_inv), .fclk_inv(fclk_inv),
    .tick(tick), .fclk_lvl(fclk_lvl), .data_bit(data_bit)
  );

  asrx_framer #(.SLOT_W(SLOT_W), .TDM_SLOTS(TDM_SLOTS)) u_framer (
    .clk(clk), .rst(rst), .tdm(fmt_sel == 2'd3),
    .tick(tick), .fclk_lvl(fclk_lvl), .data_bit(data_bit),
    .bit_vld(bit_vld), .bit_pos(bit_pos), .bit_d(bit_d), .bit_lr(bit_lr),
    .ferr(frame_err)
  );

  asrx_assemble #(.SAMPLE_W(SAMPLE_W), .SLOT_W(SLOT_W), .TDM_SLOTS(TDM_SLOTS)) u_asm (
    .clk(clk), .rst(rst), .fmt(fmt_sel), .wcode(wlen_sel),
    .bit_vld(bit_vld), .bit_pos(bit_pos), .bit_d(bit_d), .bit_lr(bit_lr),
    .smp_vld(smp_vld), .smp_chan(smp_chan), .smp_data(smp_data)
  );
endmodule

// File: tb/audio_serial_rx_bench.sv
module audio_serial_rx_bench;
  localparam int H = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ser_bclk = 1'b0, ser_fclk = 1'b0, ser_data = 1'b0;
  logic [1:0] fmt_sel = 2'd0, wlen_sel = 2'd0;
  logic bclk_inv = 1'b0, fclk_inv = 1'b0;
  logic smp_vld, frame_err;
  logic [2:0] smp_chan;
  logic [23:0] smp_data;

  always #4 clk = ~clk;

  audio_serial_rx u_audio_serial_rx (
    .clk(clk), .rst(rst), .ser_bclk(ser_bclk), .ser_fclk(ser_fclk), .ser_data(ser_data),
    .fmt_sel(fmt_sel), .wlen_sel(wlen_sel), .bclk_inv(bclk_inv), .fclk_inv(fclk_inv),
    .smp_vld(smp_vld), .smp_chan(smp_chan), .smp_data(smp_data), .frame_err(frame_err)
  );

  int total = 0, bad = 0;
  bit done = 1'b0;
  int n_got = 0, n_exp = 0, n_err = 0;
  logic [2:0]  got_ch [0:63];
  logic [23:0] got_d  [0:63];
  logic [2:0]  exp_ch [0:63];
  logic [23:0] exp_d  [0:63];
  logic [23:0] smp [0:7];

  always @(negedge clk) begin
    if (!rst) begin
      if (smp_vld && n_got < 64) begin
        got_ch[n_got] = smp_chan;
        got_d[n_got]  = smp_data;
        n_got++;
      end
      if (frame_err) n_err++;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int wbits(input logic [1:0] c);
    return (c == 2'd1) ? 20 : (c == 2'd2) ? 16 : 24;
  endfunction

  function automatic string ftag(input logic [1:0] f);
    case (f)
      2'd0: return "R1";
      2'd1: return "R2";
      2'd2: return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic send_bit(input logic lr, input logic d);
    @(negedge clk);
    ser_bclk = bclk_inv; ser_fclk = lr ^ fclk_inv; ser_data = d;
    repeat (H) @(negedge clk);
    ser_bclk = ~bclk_inv;
    repeat (H - 1) @(negedge clk);
  endtask

  // send one frame (or its first 'cut' bits) and record the words it completes
  task automatic send_frame(input int cut);
    int w, nb;
    logic [23:0] m;
    w  = wbits(wlen_sel);
    nb = (fmt_sel == 2'd3) ? 256 : 64;
    m  = 24'hFFFFFF << (24 - w);
    for (int i = 0; i < 8; i++) smp[i] = 24'($urandom);
    for (int b = 0; b < nb && b < cut; b++) begin
      logic lr, d;
      int h, o, k;
      d = 1'($urandom);
      if (fmt_sel == 2'd3) begin
        lr = (b < 32);
        h  = (b - 1) / 32;
        k  = (b - 1) % 32;
        if (b >= 1 && k < w) d = smp[h][23-k];
      end else begin
        h  = b / 32;
        o  = b % 32;
        lr = (fmt_sel == 2'd0) ? 1'(h) : 1'(1 - h);
        k  = (fmt_sel == 2'd0) ? o - 1 : (fmt_sel == 2'd1) ? o : o - (32 - w);
        if (k >= 0 && k < w) d = smp[h][23-k];
      end
      send_bit(lr, d);
    end
    for (int s = 0; s < ((fmt_sel == 2'd3) ? 8 : 2); s++) begin
      int lastb;
      case (fmt_sel)
        2'd0: lastb = 32*s + w;
        2'd1: lastb = 32*s + w - 1;
        2'd2: lastb = 32*s + 31;
        default: lastb = 32*s + w;
      endcase
      if (lastb < cut) begin
        exp_ch[n_exp] = 3'(s);
        exp_d[n_exp]  = smp[s] & m;
        n_exp++;
      end
    end
  endtask

  task automatic start_run(input logic [1:0] f, input logic [1:0] wc,
                           input logic bi, input logic fi);
    logic idle_lr;
    rst = 1'b1;
    fmt_sel = f; wlen_sel = wc; bclk_inv = bi; fclk_inv = fi;
    idle_lr = (f == 2'd0);
    ser_bclk = bi; ser_fclk = idle_lr ^ fi; ser_data = 1'b0;
    repeat (6) @(negedge clk);
    rst = 1'b0;
    n_got = 0; n_exp = 0; n_err = 0;
    for (int i = 0; i < 4; i++) send_bit(idle_lr, 1'($urandom));
    repeat (4) @(negedge clk);
    chk(n_got == 0, "R8", "word before first frame edge", n_got, 0);
  endtask

  task automatic compare(input string tag);
    repeat (20) @(negedge clk);
    chk(n_got == n_exp, tag, "word count", n_got, n_exp);
    for (int i = 0; i < n_exp && i < n_got; i++) begin
      chk(got_ch[i] == exp_ch[i], tag, $sformatf("chan of word %0d", i), got_ch[i], exp_ch[i]);
      chk(got_d[i] == exp_d[i], {tag, "/R5"}, $sformatf("data of word %0d", i), got_d[i], exp_d[i]);
    end
  endtask

  initial begin
    repeat (5) @(negedge clk);
    // R10: outputs quiet in reset
    chk(smp_vld == 0 && frame_err == 0, "R10", "strobes in reset", {smp_vld, frame_err}, 0);
    chk(smp_data == 0 && smp_chan == 0, "R10", "data in reset", {smp_chan, smp_data}, 0);

    for (int f = 0; f < 4; f++)
      for (int wc = 0; wc < 3; wc++)
        for (int pol = 0; pol < 4; pol++) begin
          string tag;
          start_run(2'(f), 2'(wc), pol[0], pol[1]);
          send_frame(1000);
          send_frame(1000);
          tag = $sformatf("%s/%s", ftag(2'(f)), pol[0] ? "R6" : (pol[1] ? "R7" : "R5"));
          compare(tag);
          chk(n_err == 0, "R9", "no error on regular frames", n_err, 0);
        end

    // R9: TDM frame cut short at bit 100
    start_run(2'd3, 2'd0, 1'b0, 1'b0);
    send_frame(1000);
    send_frame(100);
    send_frame(1000);
    compare("R9");
    chk(n_err == 1, "R9", "error pulse count", n_err, 1);

    chk(smp_vld == 0, "R8", "strobe idle after stream", smp_vld, 0);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog run did not finish actual=1 expected=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule